// File: doc/BRIEF.md
# Four-Operand Rounded Averager with One Shared Adder

This block takes four unsigned words, adds them, divides the total by eight and rounds the quotient to the nearest integer, with exact halves rounded up. It does not build a tree of adders. A single adder is reused over successive clock cycles. A small controller steps the adder through the operand additions into an accumulator register, and then applies the rounding increment to the shifted total.

A job begins when `start` is high in a cycle where `ready` is high. At that clock edge the four inputs are sampled. `ready` then stays low while the sequence runs. It returns high together with the new `result`, and `result` keeps that value until the next job completes.

Top module: `quad_avg`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ready` is 1 and `result` is 0.
- R2: At the end of a job, `result` equals (inA+inB+inC+inD+4) >> 3. This is the sum shifted right by three bits, plus bit 2 of the sum.
- R3: Call the clock edge that samples `start` high with `ready` high edge 0. `ready` is 0 after edges 1 to 3. `ready` is 1 again after edge 4, and the new `result` is present at that point.
- R4: The operands are taken only at edge 0. Changing the four data inputs while `ready` is 0 does not change the result of the job.
- R5: `start` has no effect while `ready` is 0. Neither the job's result nor its timing changes.
- R6: `result` stays constant in every cycle except the one in which `ready` rises.
- R7: The accumulator is DATA_W+2 bits wide, so the sum cannot overflow. All inputs at their maximum give 2^(DATA_W-1).
- R8: A sum whose low three bits are 100 rounds up. A sum whose low three bits are 011 rounds down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a job; acted on only when `ready` is high |
| inA | input | DATA_W | First operand |
| inB | input | DATA_W | Second operand |
| inC | input | DATA_W | Third operand |
| inD | input | DATA_W | Fourth operand |
| result | output | DATA_W | Rounded average of the last finished job |
| ready | output | 1 | High when idle and able to accept `start` |

## Verification
The checker assumes the following about the inputs:
- `rst` is held for at least one clock edge at time zero.
- The data inputs are plain unsigned values.
- `start` may arrive at any time, including while a job is running.

Under these assumptions it bounds the length of the busy window and requires `result` to be stable outside completion. The stimulus also drives `start` and scrambles the data inputs during busy cycles, so R4 and R5 are exercised. Every value of the four-operand sum from 0 to its maximum is visited, and a run of pseudo-random operand sets follows.

// File: rtl/quad_avg_pkg.sv
package quad_avg_pkg;

  typedef enum logic [1:0] {
    SEL_B   = 2'd0,
    SEL_C   = 2'd1,
    SEL_D   = 2'd2,
    SEL_RND = 2'd3
  } addSel_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDB = 3'd1,
    ST_ADDC = 3'd2,
    ST_ADDD = 3'd3,
    ST_RND  = 3'd4
  } avgState_t;

  typedef struct packed {
    logic    loadOps;
    logic    accWrite;
    logic    resWrite;
    addSel_t sel;
  } ctrlStrobes_t;

endpackage

// File: rtl/quad_avg_ctrl.sv
module quad_avg_ctrl
  import quad_avg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         ready
);

  avgState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '{loadOps: 1'b0, accWrite: 1'b0, resWrite: 1'b0, sel: SEL_B};
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.loadOps = 1'b1;
          nextState       = ST_ADDB;
        end
      end
      ST_ADDB: begin
        strobes.accWrite = 1'b1;
        strobes.sel      = SEL_B;
        nextState        = ST_ADDC;
      end
      ST_ADDC: begin
        strobes.accWrite = 1'b1;
        strobes.sel      = SEL_C;
        nextState        = ST_ADDD;
      end
      ST_ADDD: begin
        strobes.accWrite = 1'b1;
        strobes.sel      = SEL_D;
        nextState        = ST_RND;
      end
      ST_RND: begin
        strobes.resWrite = 1'b1;
        strobes.sel      = SEL_RND;
        nextState        = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign ready = (state == ST_IDLE);

endmodule

// File: rtl/quad_avg_dpath.sv
module quad_avg_dpath
  import quad_avg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic [DATA_W-1:0] inC,
  input  logic [DATA_W-1:0] inD,
  output logic [DATA_W-1:0] result
);

  localparam int SUM_W    = DATA_W + 2;
  localparam int SHIFT    = 3;
  localparam int N_HELD   = 3;

  logic [DATA_W-1:0] heldOp [N_HELD];
  logic [DATA_W-1:0] newOp  [N_HELD];
  logic [SUM_W-1:0]  acc;
  logic [SUM_W-1:0]  addX, addY, addOut;
  logic [DATA_W-1:0] resReg;

  assign newOp[0] = inB;
  assign newOp[1] = inC;
  assign newOp[2] = inD;

  for (genvar gi = 0; gi < N_HELD; gi++) begin : g_held
    always_ff @(posedge clk) begin
      if (rst)                  heldOp[gi] <= '0;
      else if (strobes.loadOps) heldOp[gi] <= newOp[gi];
    end
  end

  always_comb begin
    addX = acc;
    addY = '0;
    unique case (strobes.sel)
      SEL_B:   addY = SUM_W'(heldOp[0]);
      SEL_C:   addY = SUM_W'(heldOp[1]);
      SEL_D:   addY = SUM_W'(heldOp[2]);
      SEL_RND: begin
        addX = acc >> SHIFT;
        addY = SUM_W'(acc[SHIFT-1]);
      end
      default: addY = '0;
    endcase
  end

  assign addOut = addX + addY;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      resReg <= '0;
    end else begin
      if (strobes.loadOps)       acc    <= SUM_W'(inA);
      else if (strobes.accWrite) acc    <= addOut;
      if (strobes.resWrite)      resReg <= addOut[DATA_W-1:0];
    end
  end

  assign result = resReg;

endmodule

// File: rtl/quad_avg.sv
module quad_avg
  import quad_avg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic [DATA_W-1:0] inC,
  input  logic [DATA_W-1:0] inD,
  output logic [DATA_W-1:0] result,
  output logic              ready
);

  ctrlStrobes_t strobes;

  quad_avg_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strobes (strobes),
    .ready   (ready)
  );

  quad_avg_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inA     (inA),
    .inB     (inB),
    .inC     (inC),
    .inD     (inD),
    .result  (result)
  );

endmodule

// File: rtl/quad_avg_check.sv
module quad_avg_check #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [DATA_W-1:0] result,
  input logic              ready
);

  localparam int MAX_BUSY = 4;
  localparam logic [DATA_W-1:0] TOP_VAL = DATA_W'(1) << (DATA_W - 1);

  logic [2:0] busyCnt;

  always_ff @(posedge clk) begin
    if (rst || ready) busyCnt <= '0;
    else              busyCnt <= busyCnt + 3'd1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready && result == '0)); // R1

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> !ready); // R3

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (busyCnt < 3'(MAX_BUSY))); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$rose(ready) |-> $stable(result)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    result <= TOP_VAL); // R7

endmodule

bind quad_avg quad_avg_check #(.DATA_W(DATA_W)) u_check (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .result (result),
  .ready  (ready)
);

// File: tb/quad_avg_test.sv
module quad_avg_test;

  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] inA = '0, inB = '0, inC = '0, inD = '0;
  logic [W-1:0] result;
  logic         ready;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  quad_avg #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .start(start),
    .inA(inA), .inB(inB), .inC(inC), .inD(inD),
    .result(result), .ready(ready)
  );

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int expAvg(input int a, input int b, input int c, input int d);
    return (a + b + c + d + 4) >> 3;
  endfunction

  // One job; optional disturbance of inputs and start during the busy window.
  task automatic runJob(input int a, input int b, input int c, input int d,
                        input bit disturb, input string req);
    @(negedge clk);
    inA = W'(a); inB = W'(b); inC = W'(c); inD = W'(d);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = disturb;
    if (disturb) begin
      inA = W'(~a); inB = W'(~b); inC = W'(c + 77); inD = W'(d ^ 5);
    end
    check("R3 busy after start", int'(ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (disturb) begin
        inA = W'(a + k * 31); inB = W'(b + 13); inC = W'(k); inD = W'(~d);
      end
      if (k == 2) check("R3 still busy after edge 3", int'(ready), 0);
    end
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R3 ready after edge 4", int'(ready), 1);
    check(req, int'(result), expAvg(a, b, c, d));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready in reset", int'(ready), 1);
    check("R1 result in reset", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", int'(ready), 1);
    check("R1 result after reset", int'(result), 0);

    // Rounding corners: R8
    runJob(4, 0, 0, 0, 1'b0, "R8 sum 4 rounds up");
    runJob(3, 0, 0, 0, 1'b0, "R8 sum 3 rounds down");
    runJob(10, 2, 0, 0, 1'b0, "R8 sum 12 rounds up");
    runJob(5, 3, 2, 1, 1'b0, "R8 sum 11 rounds down");
    runJob(MAXV, MAXV, MAXV, MAXV, 1'b0, "R7 all max");
    runJob(0, 0, 0, 0, 1'b0, "R2 all zero");

    // R4/R5: inputs and start disturbed while busy
    runJob(200, 17, 99, 3, 1'b1, "R4 R5 disturbed job");
    runJob(MAXV, 1, 128, 64, 1'b1, "R4 R5 disturbed job 2");

    // R6: result holds while idle with inputs moving
    begin
      int held;
      held = int'(result);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        inA = W'(k * 40); inB = W'(k + 9); inC = W'(~k); inD = W'(k * 3);
      end
      @(negedge clk);
      check("R6 result held while idle", int'(result), held);
      check("R6 ready held while idle", int'(ready), 1);
    end

    // R2 sweep over every reachable sum value
    for (int s = 0; s <= 4 * MAXV; s++) begin
      int rem, a, b, c, d;
      rem = s;
      a = (rem > MAXV) ? MAXV : rem; rem -= a;
      b = (rem > MAXV) ? MAXV : rem; rem -= b;
      c = (rem > MAXV) ? MAXV : rem; rem -= c;
      d = rem;
      runJob(d, c, a, b, s[4], "R2 sum sweep");
    end

    // R2 pseudo-random operand sets
    begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2345;
      for (int n = 0; n < 600; n++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        runJob(int'(lfsr[7:0]), int'(lfsr[15:8]), int'(lfsr[23:16]),
               int'(lfsr[31:24]), lfsr[3], "R2 random");
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule